// File: doc/BRIEF.md
# Oversampled Serial Receiver with Majority-Vote Bit Decisions

This block recovers bytes from an asynchronous serial line that may be noisy, for example the sliced output of a simple radio demodulator. The line is first passed through a two-stage synchronizer. It is then read only on clock edges where a sample strobe is high. The strobe runs at four times the bit rate, so a 9600 bit/s link needs a 38400 Hz strobe.

While hunting, the receiver waits for a run of consecutive low samples before it accepts a start bit. This lets short noise dips on the idle line pass without effect. The first low sample of the accepted run sets the sample phase for the rest of the frame. Each later bit is decided by a majority vote over the three samples that follow its first sample, so the sample nearest the bit edge is ignored. The frame is one low start bit, eight data bits sent least significant first, and one high stop bit. A good frame updates the output byte and pulses `valid` for one cycle. A frame with a low stop bit is dropped, and `ferr` pulses for one cycle. Parameters: `OVS` (samples per bit, default 4), `QUAL` (low samples needed to accept a start, from 2 up to `OVS`, default 3) and `NBITS` (default 8).

Top module: `os_uart_rx`

## Requirements
- R1: After reset, `valid` and `ferr` are low, `data` is zero, and the receiver is disarmed. A line held low from reset produces no output until at least one high sample has been taken.
- R2: A start bit is accepted only after 3 consecutive low samples. A low run of 1 or 2 samples followed by a high sample gives neither `valid` nor `ferr`. A run of exactly 3 low samples starts a frame.
- R3: Sample positions are counted from the first low sample of the start run, at 4 per bit, numbered 0 to 3 within each bit. For each bit after the start bit, the value is the majority of the samples at positions 1, 2 and 3. The sample at position 0 has no effect.
- R4: After the start bit come eight data bits, received least significant first (the first data bit received goes to `data[0]`), then one stop bit. A frame spans 40 samples.
- R5: If the voted stop bit is high, `data` takes the received byte and `valid` is high for exactly one cycle. This is the cycle after the clock edge that takes the 40th sample of the frame. `data` changes at no other time.
- R6: If the voted stop bit is low, `ferr` is high for exactly one cycle at the same point, `valid` stays low, and `data` keeps its previous value.
- R7: After a frame, a new start is qualified only if a high sample was taken during the stop-bit window or after the frame ended. A line that stays low after a bad stop bit gives no further output until it goes high.
- R8: A frame whose start bit begins on the sample right after the previous frame's stop bit is received correctly.
- R9: `valid` and `ferr` are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle sample strobe at OVS times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| data | output | NBITS | Last correctly framed byte |
| valid | output | 1 | One-cycle pulse when `data` is updated |
| ferr | output | 1 | One-cycle pulse when a frame is dropped for a bad stop bit |

## Verification
A line value the bench drives is taken on the third clock edge after it is set, because it passes through two synchronizer stages before the edge that carries the strobe. The bench therefore holds each sample for three edges and raises `tick` only on the last of them. The result of a frame appears for the single cycle after the edge that takes its 40th sample. Output pulses are counted by a monitor that samples on the falling clock edge, so each pulse is seen exactly once. Each frame is followed by two idle samples before its counts and `data` are compared with the values the bench has computed, which means no comparison falls in the cycle where a result lands.

// File: rtl/os_uart_rx.sv
`timescale 1ns/1ps
module os_uart_rx #(
  parameter int OVS   = 4,
  parameter int QUAL  = 3,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rxd,
  output logic [NBITS-1:0] data,
  output logic             valid,
  output logic             ferr
);
  localparam int PW       = $clog2(OVS + 1);
  localparam int BW       = $clog2(NBITS + 2);
  localparam int STOP_IDX = NBITS + 1;

  typedef enum logic [1:0] {HUNT, QUALIFY, FRAME} st_t;

  st_t              st;
  logic             s1, s2, armed, stop_hi;
  logic [PW-1:0]    ph, cnt, qn;
  logic [BW-1:0]    bidx;
  logic [NBITS-1:0] sh;

  wire samp    = s2;
  wire ph_last = (ph == PW'(OVS - 1));
  wire bit_now = ((int'(cnt) + int'(samp)) * 2) > (OVS - 1);
  wire [PW-1:0] ph_nxt   = ph_last ? '0 : ph + 1'b1;
  wire [BW-1:0] bidx_nxt = ph_last ? bidx + 1'b1 : bidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= HUNT;
      armed   <= 1'b0;
      stop_hi <= 1'b0;
      ph      <= '0;
      cnt     <= '0;
      qn      <= '0;
      bidx    <= '0;
      sh      <= '0;
      data    <= '0;
      valid   <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      if (tick) begin
        unique case (st)
          HUNT: begin
            if (samp) armed <= 1'b1;
            else if (armed) begin
              st   <= QUALIFY;
              qn   <= PW'(1);
              ph   <= PW'(1);
              bidx <= '0;
            end
          end
          QUALIFY: begin
            if (samp) begin
              st    <= HUNT;
              armed <= 1'b1;
            end else begin
              ph   <= ph_nxt;
              bidx <= bidx_nxt;
              qn   <= qn + 1'b1;
              if (qn == PW'(QUAL - 1)) begin
                st      <= FRAME;
                armed   <= 1'b0;
                stop_hi <= 1'b0;
              end
            end
          end
          FRAME: begin
            ph   <= ph_nxt;
            bidx <= bidx_nxt;
            cnt  <= (ph == '0) ? '0 : cnt + PW'(samp);
            if (bidx == BW'(STOP_IDX) && samp) stop_hi <= 1'b1;
            if (ph_last) begin
              if (bidx >= BW'(1) && bidx <= BW'(NBITS))
                sh <= {bit_now, sh[NBITS-1:1]};
              if (bidx == BW'(STOP_IDX)) begin
                st      <= HUNT;
                armed   <= stop_hi | samp;
                stop_hi <= 1'b0;
                if (bit_now) begin
                  valid <= 1'b1;
                  data  <= sh;
                end else begin
                  ferr <= 1'b1;
                end
              end
            end
          end
          default: st <= HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/os_uart_rx_chk.sv
`timescale 1ns/1ps
module os_uart_rx_chk #(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [NBITS-1:0] data,
  input logic             valid,
  input logic             ferr
);
  a_r9_excl: assert property (@(posedge clk) disable iff (rst) !(valid && ferr));
  a_r9_valid_single: assert property (@(posedge clk) disable iff (rst) valid |=> !valid);
  a_r9_ferr_single: assert property (@(posedge clk) disable iff (rst) ferr |=> !ferr);
  a_r5_valid_after_tick: assert property (@(posedge clk) disable iff (rst) valid |-> $past(tick));
  a_r6_ferr_after_tick: assert property (@(posedge clk) disable iff (rst) ferr |-> $past(tick));
  a_r5_data_moves_on_valid: assert property (@(posedge clk) disable iff (rst) !$stable(data) |-> valid);
endmodule

bind os_uart_rx os_uart_rx_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .data(data), .valid(valid), .ferr(ferr)
);

// File: tb/os_uart_rx_tb.sv
`timescale 1ns/1ps
module os_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rxd = 1'b0;
  logic [7:0] data;
  logic       valid, ferr;

  int checks = 0;
  int failures = 0;
  int nval = 0;
  int nferr = 0;
  logic [7:0] last = 8'h00;

  always #2.5 clk = ~clk;

  os_uart_rx u_dut (.clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
                    .data(data), .valid(valid), .ferr(ferr));

  always @(negedge clk) begin
    if (!rst) begin
      if (valid) begin
        nval = nval + 1;
        last = data;
      end
      if (ferr) nferr = nferr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_samp(input logic v);
    @(negedge clk) rxd = v;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic idle(input int n, input logic v);
    for (int i = 0; i < n; i++) put_samp(v);
  endtask

  task automatic send_bits(input logic [9:0] vals, input logic [39:0] masks);
    for (int k = 0; k < 10; k++)
      for (int p = 0; p < 4; p++) put_samp(vals[k] ^ masks[4*k+p]);
  endtask

  task automatic frame_ok(input logic [7:0] b, input logic [39:0] masks,
                          input logic [7:0] exp, input string req);
    int v0, f0;
    v0 = nval; f0 = nferr;
    send_bits({1'b1, b, 1'b0}, masks);
    idle(2, 1'b1);
    chk(nval == v0 + 1, req, nval - v0, 1);
    chk(last == exp && data == exp, req, data, exp);
    chk(nferr == f0, req, nferr - f0, 0);
  endtask

  initial begin
    #750000;
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v0, f0;
    logic [39:0] m;
    logic [7:0] kept;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(valid == 0 && ferr == 0, "R1 reset pulses", {valid, ferr}, 0);
    chk(data == 8'h00, "R1 reset data", data, 0);
    // R1 line low from reset: disarmed
    idle(30, 1'b0);
    chk(nval == 0 && nferr == 0, "R1 low from reset", nval + nferr, 0);
    idle(2, 1'b1);
    frame_ok(8'h3C, '0, 8'h3C, "R1 R4 first frame");

    // R2 glitches of one and two samples
    v0 = nval; f0 = nferr;
    put_samp(1'b0); idle(10, 1'b1);
    chk(nval == v0 && nferr == f0, "R2 one-sample glitch", nval + nferr - v0 - f0, 0);
    idle(2, 1'b0); idle(10, 1'b1);
    chk(nval == v0 && nferr == f0, "R2 two-sample glitch", nval + nferr - v0 - f0, 0);
    chk(data == 8'h3C, "R2 data kept", data, 8'h3C);
    // R2 exactly three low samples start a frame; rest high -> 0xFF
    frame_ok(8'hFF, 40'h8, 8'hFF, "R2 three-low start");

    // R3 R4 R5 sweep of all bytes, one corrupted sample per data/stop bit
    for (int b = 0; b < 256; b++) begin
      m = '0;
      for (int k = 1; k < 10; k++) m[4*k + ((b + k) % 4)] = 1'b1;
      frame_ok(8'(b), m, 8'(b), "R3 R4 R5 sweep");
    end

    // R3 all position-0 samples inverted (not the start bit)
    m = '0;
    for (int k = 1; k < 10; k++) m[4*k] = 1'b1;
    frame_ok(8'hA5, m, 8'hA5, "R3 position 0 ignored");
    // R3 two of three voting samples high flips data bit 0
    frame_ok(8'h00, 40'h60, 8'h01, "R3 majority flips");
    // R4 lsb first
    frame_ok(8'h01, '0, 8'h01, "R4 lsb first");

    // R6 bad stop then line high
    kept = data; v0 = nval; f0 = nferr;
    send_bits({1'b0, 8'h5A, 1'b0}, '0);
    idle(3, 1'b1);
    chk(nferr == f0 + 1, "R6 ferr pulse", nferr - f0, 1);
    chk(nval == v0, "R6 no valid", nval - v0, 0);
    chk(data == kept, "R6 data kept", data, kept);

    // R7 bad stop and line stays low
    v0 = nval; f0 = nferr;
    send_bits({1'b0, 8'h00, 1'b0}, '0);
    idle(25, 1'b0);
    chk(nferr == f0 + 1, "R7 single ferr", nferr - f0, 1);
    chk(nval == v0, "R7 no valid while low", nval - v0, 0);
    idle(2, 1'b1);
    frame_ok(8'hC3, '0, 8'hC3, "R7 rearmed frame");

    // R8 back-to-back frames
    v0 = nval; f0 = nferr;
    send_bits({1'b1, 8'h96, 1'b0}, '0);
    send_bits({1'b1, 8'h69, 1'b0}, '0);
    idle(2, 1'b1);
    chk(nval == v0 + 2, "R8 two frames", nval - v0, 2);
    chk(last == 8'h69, "R8 second byte", last, 8'h69);
    chk(nferr == f0, "R8 no ferr", nferr - f0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule